// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset request that can reach the chip into one system reset, one core reset and one debug-domain reset. It also keeps a record of which request caused the most recent reset. The requesting sources are:

- a key-qualified software request;
- a processor lockup indication;
- a clock-loss error;
- a reset command from the serial flash-programming port, counted only while that port is enabled;
- two level bits from the debug access port: a system reset request and a core hold.

Requests that arrive asynchronously pass through a synchroniser before they are used. The system reset is stretched to a minimum length and stays asserted for as long as a level request is present. The core reset can outlast the system reset while the debug core-hold bit is set. The cause flags are sticky and survive any system reset. Only the power-on reset input clears them, and that input is also the only thing that resets the debug domain.

Top module: `sysrst_ctrl`

## Requirements
- R1: A software request (`sw_req` high for one clock with `sw_key` equal to 0x05FA) raises `sys_rst` after the next rising clock edge and sets cause bit 0.
- R2: A software request with any other key value leaves `sys_rst` low and `rst_cause` unchanged.
- R3: A lockup indication causes a system reset and sets cause bit 1.
- R4: A clock-loss error causes a system reset and sets cause bit 2.
- R5: A programming-port reset command causes a system reset and sets cause bit 3, but only while `prog_en_in` is high. With the enable low, the command has no effect on `sys_rst` or `rst_cause`.
- R6: The debug system request keeps `sys_rst` asserted while it is held and sets cause bit 4. An asynchronous request held for H clocks gives a pulse of H+15 clocks.
- R7: A request lasting a single clock produces a `sys_rst` pulse of exactly 16 clocks.
- R8: When a request arrives while `sys_rst` is low, all cause bits are cleared and the bits of every active source are set. Sources that request at the same time all appear in the flags.
- R9: `rst_cause` keeps its value through and after a system reset. The `por_n` input, when low, clears `rst_cause` to 0 and asserts `sys_rst`, `core_rst` and `dbg_rst`.
- R10: `dbg_rst` is deasserted one clock after `por_n` releases and is never asserted by any other source.
- R11: If the debug core-hold bit is high while `sys_rst` is asserted, `core_rst` stays high after `sys_rst` falls. It then drops on the third rising edge after the hold bit is cleared.
- R12: `core_rst` is high whenever `sys_rst` is high. Setting core-hold while no system reset is in progress does not assert `core_rst`.
- R13: Asynchronous inputs pass through two flops, so `sys_rst` is still low after the second rising edge following the input change and is high after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sw_req | input | 1 | Software reset request strobe, synchronous |
| sw_key | input | 16 | Key that accompanies the software request |
| lockup_in | input | 1 | Processor lockup indication, asynchronous |
| clk_loss_in | input | 1 | Clock-loss error, asynchronous |
| prog_en_in | input | 1 | Programming-port enable, asynchronous |
| prog_cmd_in | input | 1 | Programming-port reset command, asynchronous |
| dbg_sys_in | input | 1 | Debug-port system reset request level, asynchronous |
| dbg_hold_in | input | 1 | Debug-port core-hold level, asynchronous |
| sys_rst | output | 1 | System reset, active high |
| core_rst | output | 1 | Core reset, active high |
| dbg_rst | output | 1 | Debug-domain reset, active high |
| rst_cause | output | 5 | Sticky cause flags: bit0 software, bit1 lockup, bit2 clock loss, bit3 programming port, bit4 debug request |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a 16-clock minimum stretch and the key 0x05FA. These values make the pulse lengths exact and easy to predict. A one-clock request gives exactly 16 clocks, and a level request held for H clocks gives H+15. The latency from an input change to `sys_rst` can therefore be counted edge by edge. The short stretch also keeps the core-hold release, the flag clearing between events and the power-on clearing within a few hundred clocks.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    // cause flag positions (software visible order)
    localparam int unsigned SRC_N       = 5;
    localparam int unsigned SRC_SW      = 0;
    localparam int unsigned SRC_LOCKUP  = 1;
    localparam int unsigned SRC_CLKLOSS = 2;
    localparam int unsigned SRC_PROG    = 3;
    localparam int unsigned SRC_DBG     = 4;

    typedef logic [SRC_N-1:0] src_vec_t;

    // asynchronous input lanes that share the synchroniser bank
    localparam int unsigned ASYNC_N     = 6;
    localparam int unsigned AI_LOCKUP   = 0;
    localparam int unsigned AI_CLKLOSS  = 1;
    localparam int unsigned AI_PROG_EN  = 2;
    localparam int unsigned AI_PROG_CMD = 3;
    localparam int unsigned AI_DBG_SYS  = 4;
    localparam int unsigned AI_DBG_HOLD = 5;

    typedef logic [ASYNC_N-1:0] async_vec_t;

    // top-level registered state
    typedef struct packed {
        logic dbg_rst;
        logic core_hold;
    } top_state_t;

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_in,
    output logic q_out
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], d_in};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_out = chain_q[LAST];

endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic req,
    output logic active
);

    localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } stretch_t;

    stretch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req) begin
            st_d.active = 1'b1;
            st_d.cnt    = LOAD;
        end else if (st_q.active) begin
            if (st_q.cnt == '0) st_d.active = 1'b0;
            else                st_d.cnt    = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{active: 1'b1, cnt: LOAD};
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    AST_REQ_HOLDS_RESET: assert property (@(posedge clk) disable iff (!por_n)
        req |=> st_q.active);                                              // R6
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.active && !req && st_q.cnt != '0) |=> st_q.active);          // R7

endmodule

// File: rtl/sysrst_status.sv
module sysrst_status
    import sysrst_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  src_vec_t req_vec,
    input  logic     sys_active,
    output src_vec_t flags
);

    src_vec_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (|req_vec) begin
            if (sys_active) flags_d = flags_q | req_vec;
            else            flags_d = req_vec;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_NEW_EVENT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_active && |req_vec) |=> ((flags_q & ~$past(req_vec)) == '0)); // R8
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        !(|req_vec) |=> $stable(flags_q));                                  // R9

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int unsigned         SYNC_STAGES    = 2,
    parameter int unsigned         STRETCH_CYCLES = 16,
    parameter int unsigned         KEY_W          = 16,
    parameter logic [KEY_W-1:0]    SW_KEY         = KEY_W'(16'h05FA)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sw_req,
    input  logic [KEY_W-1:0] sw_key,
    input  logic             lockup_in,
    input  logic             clk_loss_in,
    input  logic             prog_en_in,
    input  logic             prog_cmd_in,
    input  logic             dbg_sys_in,
    input  logic             dbg_hold_in,
    output logic             sys_rst,
    output logic             core_rst,
    output logic             dbg_rst,
    output logic [SRC_N-1:0] rst_cause
);

    async_vec_t async_raw, async_s;
    src_vec_t   req_vec;
    logic       sys_active;
    logic       hold_s;
    top_state_t st_d, st_q;

    always_comb begin
        async_raw              = '0;
        async_raw[AI_LOCKUP]   = lockup_in;
        async_raw[AI_CLKLOSS]  = clk_loss_in;
        async_raw[AI_PROG_EN]  = prog_en_in;
        async_raw[AI_PROG_CMD] = prog_cmd_in;
        async_raw[AI_DBG_SYS]  = dbg_sys_in;
        async_raw[AI_DBG_HOLD] = dbg_hold_in;
    end

    for (genvar g = 0; g < ASYNC_N; g++) begin : g_sync
        sysrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .por_n (por_n),
            .d_in  (async_raw[g]),
            .q_out (async_s[g])
        );
    end

    assign hold_s = async_s[AI_DBG_HOLD];

    always_comb begin
        req_vec              = '0;
        req_vec[SRC_SW]      = sw_req && (sw_key == SW_KEY);
        req_vec[SRC_LOCKUP]  = async_s[AI_LOCKUP];
        req_vec[SRC_CLKLOSS] = async_s[AI_CLKLOSS];
        req_vec[SRC_PROG]    = async_s[AI_PROG_CMD] && async_s[AI_PROG_EN];
        req_vec[SRC_DBG]     = async_s[AI_DBG_SYS];
    end

    sysrst_stretch #(.CYCLES(STRETCH_CYCLES)) u_stretch (
        .clk    (clk),
        .por_n  (por_n),
        .req    (|req_vec),
        .active (sys_active)
    );

    sysrst_status u_status (
        .clk        (clk),
        .por_n      (por_n),
        .req_vec    (req_vec),
        .sys_active (sys_active),
        .flags      (rst_cause)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dbg_rst = 1'b0;
        if (!hold_s)         st_d.core_hold = 1'b0;
        else if (sys_active) st_d.core_hold = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{dbg_rst: 1'b1, core_hold: 1'b0};
        else        st_q <= st_d;
    end

    assign sys_rst  = sys_active;
    assign core_rst = sys_active | st_q.core_hold;
    assign dbg_rst  = st_q.dbg_rst;

    AST_CORE_COVERS_SYS: assert property (@(posedge clk) disable iff (!por_n)
        sys_active |-> core_rst);                                          // R12
    AST_DBG_UNTOUCHED: assert property (@(posedge clk) disable iff (!por_n)
        !st_q.dbg_rst |=> !st_q.dbg_rst);                                  // R10
    AST_HOLD_KEEPS_CORE: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.core_hold && hold_s) |=> core_rst);                          // R11
    AST_NO_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_active && !st_q.core_hold) |=> (!st_q.core_hold));           // R12

endmodule

// File: tb/sim_sysrst_ctrl.sv
module sim_sysrst_ctrl;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         len;
        logic [4:0] flags;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        por_n, sw_req, lockup_in, clk_loss_in, prog_en_in, prog_cmd_in;
    logic        dbg_sys_in, dbg_hold_in;
    logic [15:0] sw_key;
    logic        sys_rst, core_rst, dbg_rst;
    logic [4:0]  rst_cause;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   mon_en = 1'b0;
    bit   done   = 1'b0;
    int   mon_len = 0;
    logic [4:0] mon_flags;
    exp_t mon_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysrst_ctrl u0 (
        .clk(clk), .por_n(por_n), .sw_req(sw_req), .sw_key(sw_key),
        .lockup_in(lockup_in), .clk_loss_in(clk_loss_in),
        .prog_en_in(prog_en_in), .prog_cmd_in(prog_cmd_in),
        .dbg_sys_in(dbg_sys_in), .dbg_hold_in(dbg_hold_in),
        .sys_rst(sys_rst), .core_rst(core_rst), .dbg_rst(dbg_rst),
        .rst_cause(rst_cause)
    );

    task automatic check(string req, string what, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic set_src(int idx, logic v);
        case (idx)
            0: lockup_in   = v;
            1: clk_loss_in = v;
            2: prog_en_in  = v;
            3: prog_cmd_in = v;
            4: dbg_sys_in  = v;
            default: dbg_hold_in = v;
        endcase
    endtask

    // driver: push expected pulse, then raise one asynchronous source for hold clocks
    task automatic async_pulse(int idx, int hold, logic [4:0] flags, string req);
        exp_q.push_back('{hold + 15, flags, req});
        set_src(idx, 1'b1);
        for (int k = 1; k <= ((hold > 3) ? hold : 3); k++) begin
            @(negedge clk);
            if (k == hold) set_src(idx, 1'b0);
            if (k == 2) check("R13", "still low after two edges", int'(sys_rst), 0);
            if (k == 3) check("R13", "high after three edges", int'(sys_rst), 1);
        end
    endtask

    task automatic sw_write(logic [15:0] key, bit accept, string req);
        if (accept) exp_q.push_back('{16, 5'b00001, req});
        sw_req = 1'b1;
        sw_key = key;
        @(negedge clk);
        sw_req = 1'b0;
        sw_key = '0;
        check(req, "sys_rst after software write", int'(sys_rst), int'(accept));
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (sys_rst || exp_q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    // monitor: measures every system reset pulse and compares with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (!mon_en) begin
                mon_len = 0;
            end else begin
                check("R10", "dbg_rst quiet", int'(dbg_rst), 0);
                if (sys_rst) begin
                    mon_len++;
                    mon_flags = rst_cause;
                    if (!core_rst) check("R12", "core_rst during sys_rst", 0, 1);
                end else if (mon_len > 0) begin
                    if (exp_q.size() == 0) begin
                        check("R2/R5", "unexpected reset pulse length", mon_len, 0);
                    end else begin
                        mon_e = exp_q.pop_front();
                        check(mon_e.tag, "pulse length", mon_len, mon_e.len);
                        check(mon_e.tag, "cause flags", int'(mon_flags), int'(mon_e.flags));
                    end
                    mon_len = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; sw_req = 1'b0; sw_key = '0;
        lockup_in = 1'b0; clk_loss_in = 1'b0; prog_en_in = 1'b0; prog_cmd_in = 1'b0;
        dbg_sys_in = 1'b0; dbg_hold_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "sys_rst in power-on", int'(sys_rst), 1);
        check("R9", "core_rst in power-on", int'(core_rst), 1);
        check("R9", "dbg_rst in power-on", int'(dbg_rst), 1);
        check("R9", "cause in power-on", int'(rst_cause), 0);
        por_n = 1'b1;
        @(negedge clk);
        check("R10", "dbg_rst released", int'(dbg_rst), 0);
        while (sys_rst) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R12", "core_rst idle", int'(core_rst), 0);
        mon_en = 1'b1;

        sw_write(16'h05FA, 1'b1, "R1");
        wait_idle();
        check("R9", "cause kept after release", int'(rst_cause), 5'b00001);

        sw_write(16'h05FB, 1'b0, "R2");
        repeat (25) @(negedge clk);
        check("R2", "cause after bad key", int'(rst_cause), 5'b00001);

        async_pulse(0, 1, 5'b00010, "R3");
        wait_idle();
        check("R8", "old flag cleared", int'(rst_cause), 5'b00010);

        async_pulse(1, 6, 5'b00100, "R4");
        wait_idle();

        prog_en_in = 1'b1;
        repeat (4) @(negedge clk);
        async_pulse(3, 2, 5'b01000, "R5");
        wait_idle();
        prog_en_in = 1'b0;
        repeat (4) @(negedge clk);
        prog_cmd_in = 1'b1;
        repeat (3) @(negedge clk);
        prog_cmd_in = 1'b0;
        repeat (25) @(negedge clk);
        check("R5", "disabled command ignored", int'(rst_cause), 5'b01000);
        check("R5", "no reset when disabled", int'(sys_rst), 0);

        async_pulse(4, 10, 5'b10000, "R6");
        wait_idle();

        exp_q.push_back('{17, 5'b00110, "R8"});
        lockup_in = 1'b1; clk_loss_in = 1'b1;
        repeat (2) @(negedge clk);
        lockup_in = 1'b0; clk_loss_in = 1'b0;
        wait_idle();

        async_pulse(0, 1, 5'b00010, "R7");
        wait_idle();

        dbg_hold_in = 1'b1;
        async_pulse(4, 4, 5'b10000, "R11");
        while (sys_rst) @(negedge clk);
        check("R11", "core held after release", int'(core_rst), 1);
        repeat (5) @(negedge clk);
        check("R11", "core still held", int'(core_rst), 1);
        dbg_hold_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R11", "core held two edges after clear", int'(core_rst), 1);
        @(negedge clk);
        check("R11", "core released", int'(core_rst), 0);
        repeat (3) @(negedge clk);

        dbg_hold_in = 1'b1;
        repeat (6) @(negedge clk);
        check("R12", "hold outside reset", int'(core_rst), 0);
        dbg_hold_in = 1'b0;
        repeat (4) @(negedge clk);

        mon_en = 1'b0;
        por_n = 1'b0;
        #1;
        check("R9", "cause cleared by power-on", int'(rst_cause), 0);
        check("R9", "sys_rst by power-on", int'(sys_rst), 1);
        check("R9", "dbg_rst by power-on", int'(dbg_rst), 1);
        check("R9", "core_rst by power-on", int'(core_rst), 1);
        @(negedge clk);
        por_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R9", "stretch after power-on", int'(sys_rst), 1);
        repeat (12) @(negedge clk);
        check("R9", "released after power-on", int'(sys_rst), 0);
        check("R10", "dbg_rst after power-on", int'(dbg_rst), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule